// File: doc/BRIEF.md
# Prescaled Countdown Timer with Autoreload

This block is a 32-bit down-counter on a simple word-wide register bus. Software supplies a start value, an 8-bit prescale divider and a mode. While enabled, the counter drops by one every P+1 clock cycles. When it reaches zero the block sets a sticky status flag, and that flag drives a level interrupt. In one-shot mode the counter then stays at zero. In auto-reload mode it refills from the load register and keeps running, which makes it a periodic tick source.

The bus has an address, a write strobe and write data. Read data is combinational from the address, and every access takes one cycle. The status flag is cleared by writing a one to its bit. Writing the load value also writes the live counter, so a single write both arms and restarts the timer.

Top module: `prescaled_countdown_timer`

## Requirements
- R1: Byte offsets select the registers: 0x0 load, 0x4 counter, 0x8 control, 0xC status. Any other address reads as zero, and a write to it changes no register.
- R2: The control fields are: bit 0 enable, bit 1 auto-reload, bits [15:8] the prescale value P. Reading control returns these fields, and every other bit reads as zero.
- R3: While enabled with a nonzero count, the counter falls by one every P+1 cycles. The flag rises N*(P+1) cycles after the edge that writes count N.
- R4: A write to load stores the value in both the load register and the counter, and restarts the prescale period.
- R5: A write to the counter replaces the count. When enabled, counting restarts from the new value with a fresh prescale period.
- R6: A step from a count of 1 sets the status flag. In one-shot mode the counter then holds at zero.
- R7: In auto-reload mode the expiring step refills the counter from load and counting continues. The flag rises again (load)*(P+1) cycles later.
- R8: An enable rising edge that arrives while the count is zero and auto-reload is selected first copies load into the counter.
- R9: A counter read returns zero while disabled or while the count is zero. Otherwise it returns the remaining count. A nonzero count held while disabled is kept.
- R10: Writing status with bit 0 set clears the flag, and a write with bit 0 clear leaves it. The interrupt output equals the flag. An expiry in the same cycle as a clear wins.
- R11: Reset clears load, counter, control and status, so every register reads zero and the interrupt is low.
- R12: An enabled timer with a zero count neither counts nor sets the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW (8) | Byte address of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data for bus_addr |
| irq | output | 1 | Level interrupt, equal to the status flag |

## Verification
The hardest case to reach is the second expiry in auto-reload mode. The bench must catch the first expiry, clear the flag in the following cycle, and then measure the gap to the next rise, without its own clear landing on a step edge. The bench arms the load only after enabling with a zero count. It then times both expiries from known write edges, so the reload period is measured exactly. The enable-with-zero-count pull from load is reached by writing load and then overwriting the counter with zero while disabled.

// File: rtl/prescaled_countdown_timer.sv
module prescaled_countdown_timer #(
  parameter int DW = 32,
  parameter int PW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);

  localparam logic [AW-1:0] OFF_LOAD = AW'(0);
  localparam logic [AW-1:0] OFF_CNT  = AW'(4);
  localparam logic [AW-1:0] OFF_CTRL = AW'(8);
  localparam logic [AW-1:0] OFF_STAT = AW'(12);
  localparam int PS_LSB = 8;

  logic [DW-1:0] load_q, cnt_q;
  logic          en_q, rl_q, stat_q;
  logic [PW-1:0] ps_q, div_q;

  wire wr_load = bus_we && (bus_addr == OFF_LOAD);
  wire wr_cnt  = bus_we && (bus_addr == OFF_CNT);
  wire wr_ctrl = bus_we && (bus_addr == OFF_CTRL);
  wire wr_stat = bus_we && (bus_addr == OFF_STAT);

  wire cnt_wr  = wr_load || wr_cnt;
  wire en_rise = wr_ctrl && !en_q && bus_wdata[0];
  wire running = en_q && (cnt_q != '0);
  wire step    = running && (div_q == ps_q);
  wire last    = (cnt_q == DW'(1));
  wire expire  = step && last && !cnt_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      cnt_q  <= '0;
      en_q   <= 1'b0;
      rl_q   <= 1'b0;
      ps_q   <= '0;
      div_q  <= '0;
      stat_q <= 1'b0;
    end else begin
      if (wr_load) load_q <= bus_wdata;

      if (wr_ctrl) begin
        en_q <= bus_wdata[0];
        rl_q <= bus_wdata[1];
        ps_q <= bus_wdata[PS_LSB +: PW];
      end

      if (cnt_wr)
        cnt_q <= bus_wdata;
      else if (en_rise && (cnt_q == '0) && bus_wdata[1])
        cnt_q <= load_q;
      else if (step)
        cnt_q <= last ? (rl_q ? load_q : '0) : cnt_q - DW'(1);

      if (cnt_wr || en_rise || step)
        div_q <= '0;
      else if (running)
        div_q <= div_q + PW'(1);

      if (expire)
        stat_q <= 1'b1;
      else if (wr_stat && bus_wdata[0])
        stat_q <= 1'b0;
    end
  end

  logic [DW-1:0] ctrl_rd;
  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[0] = en_q;
    ctrl_rd[1] = rl_q;
    ctrl_rd[PS_LSB +: PW] = ps_q;
  end

  always_comb begin
    case (bus_addr)
      OFF_LOAD: bus_rdata = load_q;
      OFF_CNT:  bus_rdata = running ? cnt_q : '0;
      OFF_CTRL: bus_rdata = ctrl_rd;
      OFF_STAT: bus_rdata = {{(DW-1){1'b0}}, stat_q};
      default:  bus_rdata = '0;
    endcase
  end

  assign irq = stat_q;

endmodule

// File: rtl/pct_checker.sv
module pct_checker #(
  parameter int DW = 32,
  parameter int PW = 8,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_we,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          irq,
  input logic [DW-1:0] cnt_q,
  input logic [DW-1:0] load_q,
  input logic          en_q,
  input logic [PW-1:0] ps_q,
  input logic [PW-1:0] div_q
);

  wire mapped = (bus_addr == AW'(0)) || (bus_addr == AW'(4)) ||
                (bus_addr == AW'(8)) || (bus_addr == AW'(12));

  // R1
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> bus_rdata == '0);

  // R3
  step_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && cnt_q > DW'(1) && div_q == ps_q && !bus_we) |=> cnt_q == $past(cnt_q) - DW'(1));

  // R4
  load_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(0)) |=> (cnt_q == $past(bus_wdata) && load_q == $past(bus_wdata) && div_q == '0));

  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(en_q && cnt_q == DW'(1) && div_q == ps_q));

  // R9
  cnt_read_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(4) && !en_q) |-> bus_rdata == '0);

  // R10
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(bus_we && bus_addr == AW'(12) && bus_wdata[0])) |=> irq);

endmodule

bind prescaled_countdown_timer pct_checker #(.DW(DW), .PW(PW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
  .cnt_q(cnt_q), .load_q(load_q), .en_q(en_q), .ps_q(ps_q), .div_q(div_q)
);

// File: tb/prescaled_countdown_timer_tb.sv
module prescaled_countdown_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int nvec = 0;
  int nbad = 0;

  always #2 clk = ~clk;

  prescaled_countdown_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
    bus_addr = 8'h00;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_irq(input int limit, output int cycles);
    cycles = 0;
    while (!irq && cycles < limit) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 16; a += 4) begin
      rd(8'(a), v);
      chk("R11 reset read", v, 32'h0);
    end
    chk("R11 reset irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_map;
    logic [31:0] v;
    wr(8'h00, 32'h0000_0055);
    wr(8'h10, 32'hDEAD_BEEF);
    wr(8'h05, 32'hFFFF_FFFF);
    rd(8'h10, v); chk("R1 unmapped read", v, 32'h0);
    rd(8'h06, v); chk("R1 unaligned read", v, 32'h0);
    rd(8'h00, v); chk("R1 load untouched", v, 32'h55);
    rd(8'h08, v); chk("R1 control untouched", v, 32'h0);
  endtask

  task automatic t_ctrl_readback;
    logic [31:0] v;
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, v); chk("R2 control readback", v, 32'h0000_FF03);
    wr(8'h08, 32'h0);
    wr(8'h04, 32'h0);
    wr(8'h0C, 32'h1);
  endtask

  task automatic t_oneshot;
    logic [31:0] v;
    int c;
    wr(8'h08, 32'h0000_0301);
    wr(8'h04, 32'd4);
    idle(5);
    rd(8'h04, v); chk("R3 mid count", v, 32'd3);
    wait_irq(200, c);
    chk("R3 expiry time", 32'(c + 5), 32'd16);
    idle(20);
    rd(8'h04, v); chk("R6 one-shot holds zero", v, 32'd0);
    chk("R6 flag set", {31'b0, irq}, 32'h1);
    wr(8'h0C, 32'hFFFF_FFFE);
    chk("R10 zero bit keeps flag", {31'b0, irq}, 32'h1);
    rd(8'h0C, v); chk("R10 status reads one", v, 32'h1);
    wr(8'h0C, 32'h1);
    chk("R10 clear drops irq", {31'b0, irq}, 32'h0);
    rd(8'h0C, v); chk("R10 status reads zero", v, 32'h0);
  endtask

  task automatic t_restart;
    logic [31:0] v;
    int c;
    wr(8'h08, 32'h0000_0001);
    wr(8'h04, 32'd10);
    idle(4);
    rd(8'h04, v); chk("R5 counting", v, 32'd6);
    wr(8'h04, 32'd3);
    rd(8'h04, v); chk("R5 replaced count", v, 32'd3);
    wait_irq(200, c);
    chk("R5 restart timing", 32'(c), 32'd3);
    wr(8'h0C, 32'h1);
  endtask

  task automatic t_load_write;
    logic [31:0] v;
    int c;
    wr(8'h08, 32'h0000_0201);
    wr(8'h00, 32'd5);
    rd(8'h04, v); chk("R4 load mirrors counter", v, 32'd5);
    rd(8'h00, v); chk("R4 load stored", v, 32'd5);
    wait_irq(200, c);
    chk("R4 load restart timing", 32'(c), 32'd15);
    wr(8'h0C, 32'h1);
  endtask

  task automatic t_autoreload;
    logic [31:0] v;
    int c;
    wr(8'h08, 32'h0);
    wr(8'h04, 32'h0);
    wr(8'h00, 32'h0);
    wr(8'h08, 32'h0000_0103);
    wr(8'h00, 32'd3);
    wait_irq(200, c);
    chk("R7 first period", 32'(c), 32'd6);
    wr(8'h0C, 32'h1);
    chk("R7 cleared between", {31'b0, irq}, 32'h0);
    wait_irq(200, c);
    chk("R7 reload period", 32'(c), 32'd5);
    wr(8'h08, 32'h0);
    wr(8'h0C, 32'h1);
  endtask

  task automatic t_enable_pull;
    logic [31:0] v;
    int c;
    wr(8'h08, 32'h0);
    wr(8'h00, 32'd7);
    wr(8'h04, 32'd0);
    wr(8'h08, 32'h0000_0003);
    rd(8'h04, v); chk("R8 pulled from load", v, 32'd7);
    wait_irq(200, c);
    chk("R8 expiry time", 32'(c), 32'd7);
    wr(8'h08, 32'h0);
    wr(8'h0C, 32'h1);
  endtask

  task automatic t_disabled_read;
    logic [31:0] v;
    int c;
    wr(8'h08, 32'h0);
    wr(8'h04, 32'd9);
    rd(8'h04, v); chk("R9 disabled reads zero", v, 32'd0);
    idle(5);
    wr(8'h08, 32'h0000_0001);
    rd(8'h04, v); chk("R9 held count visible", v, 32'd9);
    wait_irq(200, c);
    chk("R9 held count expiry", 32'(c), 32'd9);
    wr(8'h08, 32'h0);
    wr(8'h0C, 32'h1);
  endtask

  task automatic t_zero_enabled;
    logic [31:0] v;
    int c;
    wr(8'h04, 32'd0);
    wr(8'h08, 32'h0000_0001);
    wait_irq(40, c);
    chk("R12 no flag at zero", {31'b0, irq}, 32'h0);
    rd(8'h04, v); chk("R12 count stays zero", v, 32'd0);
    wr(8'h08, 32'h0);
  endtask

  initial begin
    #(4 * 150000);
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_ctrl_readback();
    t_oneshot();
    t_restart();
    t_load_write();
    t_autoreload();
    t_enable_pull();
    t_disabled_read();
    t_zero_enabled();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule